// File: doc/BRIEF.md
# Pseudo-static RAM sequencer with refresh guard

This block turns single-word requests from a synchronous valid/ready port into cycles on an external 1M x 16 pseudo-static RAM that has an asynchronous SRAM-style pin set. It drives the word address, the write data with its output enable, the active-low primary select, the active-high secondary select, the output and write strobes, and one active-low strobe per byte lane. Read data comes back on a result port together with a one-cycle valid pulse.

The memory refreshes its cells only while it is deselected, and it needs a settling period after power-up. For that reason the sequencer holds off all traffic for an initialisation window after reset. A counter of selected cycles forces a deselect gap once a threshold with margin has been crossed. When a request is already waiting at the end of an access and the threshold has not been reached, the device stays selected and the next access starts at once. Every timing figure is a nanosecond parameter, turned into a clock-cycle count by rounding up.

Top module: `psram_seq_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, mem_cs_n=1, mem_cs2=0, mem_oe_n=1, mem_we_n=1, mem_ub_n=1, mem_lb_n=1, req_ready=0 and rsp_valid=0.
- R2: After reset the device stays deselected (mem_cs_n=1) and req_ready stays 0 for at least ceil(INIT_NS/CLK_NS) cycles, which is 2500 at the defaults. A request held valid in that window starts nothing.
- R3: An accepted read drives mem_cs_n=0, mem_cs2=1, mem_oe_n=0 and mem_we_n=1. It captures mem_dq_in and pulses rsp_valid for exactly one cycle, RD_CYC clock edges after the accepting edge (3 at the defaults, where RD_CYC is the largest of the rounded-up address access, output-enable access and read cycle minus one).
- R4: An accepted write holds mem_we_n low for WR_CYC cycles (3 at the defaults) with mem_oe_n high throughout, and with address and write data unchanged. The write strobe rises one cycle before the address, data and byte strobes are released.
- R5: Byte enable bit 1 drives mem_ub_n (data bits 15:8) and bit 0 drives mem_lb_n (bits 7:0), with a strobe low when its enable is 1. A partial write changes only the enabled lane of the word read back.
- R6: A write with byte enable 00 asserts neither byte strobe and leaves the stored word unchanged.
- R7: The device is never continuously selected for more than SEL_MAX_NS/CLK_NS cycles (750 at the defaults). Once (SEL_MAX_NS-SEL_MARGIN_NS)/CLK_NS selected cycles (700) have elapsed, the device is deselected at the end of the current access.
- R8: Every deselect that follows a selected period keeps mem_cs_n high for at least GAP_CYC+1 cycles (2 at the defaults).
- R9: When a read request waits at the end of a read and the limit has not been reached, the next read follows without a deselect, so back-to-back reads return results every RD_CYC+1 cycles (4 at the defaults).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper lane, bit 0 lower lane |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | 16 | Read result |
| mem_addr | output | 20 | Memory address pins |
| mem_dq_out | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |
| mem_dq_in | input | 16 | Data received from memory |
| mem_cs_n | output | 1 | Primary select, active low |
| mem_cs2 | output | 1 | Secondary select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |

## Verification
A read result is due three clock edges after the edge that accepts the request. The bench drives requests on falling edges and counts falling edges from acceptance to the result strobe, so it expects exactly three. In a held stream of reads the results are due four cycles apart, and the bench checks this as a 36-cycle span over ten results. A write is judged by reading the word back after the ready signal returns. Pulse widths, the initialisation wait, the select-run ceiling and the gap widths are counted on every falling edge by a memory model in the bench and compared with the cycle counts the requirements give.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_WR_END,
    ST_GAP
  } psram_st_t;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_init_wait.sv
module psram_init_wait #(
  parameter int unsigned WAIT_CYC = 2500,
  localparam int unsigned W = $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  output logic done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
      if (cnt == W'(WAIT_CYC - 1)) done <= 1'b1;
    end
  end

endmodule

// File: rtl/psram_sel_guard.sv
module psram_sel_guard #(
  parameter int unsigned LIM_CYC = 700,
  parameter int unsigned MAX_CYC = 750,
  localparam int unsigned W = $clog2(MAX_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_on,
  output logic over_lim
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (!sel_on)               cnt <= '0;
    else if (cnt != W'(MAX_CYC))    cnt <= cnt + 1'b1;
  end

  assign over_lim = (cnt >= W'(LIM_CYC));

  // R7: the selected run stays below the hard ceiling
  assert_sel_window_R7: assert property (@(posedge clk) disable iff (rst)
    cnt < W'(MAX_CYC));

endmodule

// File: rtl/psram_cycle_fsm.sv
module psram_cycle_fsm
  import psram_pkg::*;
#(
  parameter int unsigned AW      = 20,
  parameter int unsigned DW      = 16,
  parameter int unsigned RD_CYC  = 3,
  parameter int unsigned WR_CYC  = 3,
  parameter int unsigned GAP_CYC = 1,
  localparam int unsigned MAXC = max2(max2(RD_CYC, WR_CYC), GAP_CYC),
  localparam int unsigned CW   = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_done,
  input  logic          over_lim,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_cs_n,
  output logic          mem_cs2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n
);

  psram_st_t     st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_INIT;
      cnt        <= '0;
      req_ready  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      mem_cs_n   <= 1'b1;
      mem_cs2    <= 1'b0;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_INIT: begin
          if (init_done) begin
            st        <= ST_IDLE;
            req_ready <= 1'b1;
          end
        end
        ST_IDLE: begin
          if (req_valid) begin
            req_ready <= 1'b0;
            cnt       <= '0;
            mem_cs_n  <= 1'b0;
            mem_cs2   <= 1'b1;
            mem_addr  <= req_addr;
            mem_ub_n  <= !req_be[1];
            mem_lb_n  <= !req_be[0];
            if (req_write) begin
              mem_we_n   <= 1'b0;
              mem_dq_out <= req_wdata;
              mem_dq_oe  <= 1'b1;
              st         <= ST_WR;
            end else begin
              mem_oe_n <= 1'b0;
              st       <= ST_RD;
            end
          end else if (!mem_cs_n) begin
            req_ready <= 1'b0;
            cnt       <= '0;
            mem_cs_n  <= 1'b1;
            mem_cs2   <= 1'b0;
            st        <= ST_GAP;
          end
        end
        ST_RD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(RD_CYC - 1)) begin
            rsp_rdata <= mem_dq_in;
            rsp_valid <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            if (over_lim) begin
              cnt      <= '0;
              mem_cs_n <= 1'b1;
              mem_cs2  <= 1'b0;
              st       <= ST_GAP;
            end else begin
              st        <= ST_IDLE;
              req_ready <= 1'b1;
            end
          end
        end
        ST_WR: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(WR_CYC - 1)) begin
            mem_we_n <= 1'b1;
            st       <= ST_WR_END;
          end
        end
        ST_WR_END: begin
          mem_ub_n  <= 1'b1;
          mem_lb_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          if (over_lim) begin
            cnt      <= '0;
            mem_cs_n <= 1'b1;
            mem_cs2  <= 1'b0;
            st       <= ST_GAP;
          end else begin
            st        <= ST_IDLE;
            req_ready <= 1'b1;
          end
        end
        ST_GAP: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(GAP_CYC - 1)) begin
            st        <= ST_IDLE;
            req_ready <= 1'b1;
          end
        end
        default: st <= ST_INIT;
      endcase
    end
  end

  // R8: a deselect lasts at least two cycles
  assert_gap_width_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_cs_n) |=> mem_cs_n);

  // R4: write strobe pulse is wider than one cycle
  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |=> !mem_we_n);

  // R4: address and data hold still while the write strobe stays low
  assert_wr_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

endmodule

// File: rtl/psram_seq_ctrl.sv
module psram_seq_ctrl
  import psram_pkg::*;
#(
  parameter int unsigned CLK_NS        = 20,
  parameter int unsigned INIT_NS       = 50000,
  parameter int unsigned T_RC_NS       = 55,
  parameter int unsigned T_AA_NS       = 55,
  parameter int unsigned T_OE_NS       = 25,
  parameter int unsigned T_WC_NS       = 55,
  parameter int unsigned T_WP_NS       = 45,
  parameter int unsigned T_AW_NS       = 45,
  parameter int unsigned T_DS_NS       = 25,
  parameter int unsigned SEL_MAX_NS    = 15000,
  parameter int unsigned SEL_MARGIN_NS = 1000,
  parameter int unsigned GAP_NS        = 5,
  parameter int unsigned AW            = 20,
  parameter int unsigned DW            = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_cs_n,
  output logic          mem_cs2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n
);

  localparam int unsigned INIT_CYC = ceil_div(INIT_NS, CLK_NS);
  localparam int unsigned RD_CYC   = max2(max2(ceil_div(T_AA_NS, CLK_NS), ceil_div(T_OE_NS, CLK_NS)),
                                          ceil_div(T_RC_NS, CLK_NS) - 1);
  localparam int unsigned WR_CYC   = max2(max2(ceil_div(T_WP_NS, CLK_NS), ceil_div(T_AW_NS, CLK_NS)),
                                          max2(ceil_div(T_DS_NS, CLK_NS), ceil_div(T_WC_NS, CLK_NS) - 1));
  localparam int unsigned SEL_MAX  = SEL_MAX_NS / CLK_NS;
  localparam int unsigned SEL_LIM  = (SEL_MAX_NS - SEL_MARGIN_NS) / CLK_NS;
  localparam int unsigned GAP_CYC  = GAP_NS / CLK_NS + 1;

  logic init_done;
  logic over_lim;

  psram_init_wait #(.WAIT_CYC(INIT_CYC)) init_i (
    .clk  (clk),
    .rst  (rst),
    .done (init_done)
  );

  psram_sel_guard #(.LIM_CYC(SEL_LIM), .MAX_CYC(SEL_MAX)) guard_i (
    .clk      (clk),
    .rst      (rst),
    .sel_on   (!mem_cs_n && mem_cs2),
    .over_lim (over_lim)
  );

  psram_cycle_fsm #(
    .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .GAP_CYC(GAP_CYC)
  ) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .init_done  (init_done),
    .over_lim   (over_lim),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in),
    .mem_cs_n   (mem_cs_n),
    .mem_cs2    (mem_cs2),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_ub_n   (mem_ub_n),
    .mem_lb_n   (mem_lb_n)
  );

  // R2: no select and no ready before the init window ends
  assert_init_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (mem_cs_n && !req_ready));

  // R4: output enable never overlaps the write strobe
  assert_no_contention_R4: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));

  // R3: a result follows a cycle with output enable low, and lasts one cycle
  assert_rsp_after_oe_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!mem_oe_n));
  assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/psram_seq_ctrl_tb.sv
module psram_seq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [19:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in = '0;
  logic        mem_cs_n, mem_cs2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;

  always #10 clk = ~clk;

  psram_seq_ctrl dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in),
    .mem_cs_n(mem_cs_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory model and pin monitors
  logic [15:0] mdl [int unsigned];
  int  since_rst = 0;
  int  first_sel = -1;
  int  sel_run = 0, max_sel_run = 0;
  int  desel_run = 0, min_gap = 1000;
  int  we_run = 0, we_min = 1000, we_max = 0;
  bit  seen_sel = 0, prev_sel = 0, prev_we_low = 0, prev_wr = 0;
  bit  bad_oe = 0, bad_stable = 0, bad_order = 0;
  logic [19:0] prev_addr = '0, wr_addr = '0;
  logic [15:0] prev_dq = '0, wr_data = '0;
  logic        prev_ub = 1'b1, prev_lb = 1'b1, wr_ub = 1'b1, wr_lb = 1'b1;

  function automatic logic [15:0] mdl_rd(input logic [19:0] a);
    if (mdl.exists(int'(a))) return mdl[int'(a)];
    return 16'h0000;
  endfunction

  always @(negedge clk) begin
    logic sel, wr_act;
    logic [15:0] w;
    if (!rst) begin
      since_rst++;
      sel    = !mem_cs_n && mem_cs2;
      wr_act = sel && !mem_we_n && (!mem_ub_n || !mem_lb_n);
      if (sel) begin
        if (first_sel < 0) first_sel = since_rst;
        if (seen_sel && !prev_sel && desel_run < min_gap) min_gap = desel_run;
        seen_sel = 1;
        sel_run++;
        if (sel_run > max_sel_run) max_sel_run = sel_run;
        desel_run = 0;
      end else begin
        sel_run = 0;
        desel_run++;
      end
      if (!mem_we_n) begin
        we_run++;
        if (!mem_oe_n) bad_oe = 1;
        if (prev_we_low && (mem_addr !== prev_addr || mem_dq_out !== prev_dq)) bad_stable = 1;
      end else if (prev_we_low) begin
        if (we_run < we_min) we_min = we_run;
        if (we_run > we_max) we_max = we_run;
        we_run = 0;
        if (mem_ub_n !== prev_ub || mem_lb_n !== prev_lb || mem_addr !== prev_addr ||
            mem_dq_out !== prev_dq) bad_order = 1;
      end
      if (wr_act) begin
        wr_addr = mem_addr; wr_data = mem_dq_out; wr_ub = mem_ub_n; wr_lb = mem_lb_n;
      end else if (prev_wr) begin
        w = mdl_rd(wr_addr);
        if (!wr_ub) w[15:8] = wr_data[15:8];
        if (!wr_lb) w[7:0]  = wr_data[7:0];
        mdl[int'(wr_addr)] = w;
      end
      if (sel && !mem_oe_n && mem_we_n) begin
        w = mdl_rd(mem_addr);
        mem_dq_in <= {mem_ub_n ? 8'h00 : w[15:8], mem_lb_n ? 8'h00 : w[7:0]};
      end else begin
        mem_dq_in <= 16'h0000;
      end
      prev_sel = sel; prev_we_low = !mem_we_n; prev_wr = wr_act;
      prev_addr = mem_addr; prev_dq = mem_dq_out; prev_ub = mem_ub_n; prev_lb = mem_lb_n;
    end
  end

  // starts and ends at a falling edge
  task automatic do_access(input logic w, input logic [19:0] a, input logic [15:0] d,
                           input logic [1:0] be, output logic [15:0] rd, output int lat);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    rd = '0;
    if (!w) begin
      while (!rsp_valid && lat < 50) begin
        @(negedge clk);
        lat++;
      end
      rd = rsp_rdata;
    end
  endtask

  // {write, addr[19:0], wdata[15:0], be[1:0], expected[15:0]}
  localparam logic [54:0] VECS [0:11] = '{
    {1'b1, 20'h00010, 16'hA5C3, 2'b11, 16'h0000},
    {1'b1, 20'h00011, 16'h1234, 2'b11, 16'h0000},
    {1'b0, 20'h00010, 16'h0000, 2'b11, 16'hA5C3},
    {1'b1, 20'h00010, 16'h77EE, 2'b01, 16'h0000},
    {1'b0, 20'h00010, 16'h0000, 2'b11, 16'hA5EE},
    {1'b1, 20'h00011, 16'h9988, 2'b10, 16'h0000},
    {1'b0, 20'h00011, 16'h0000, 2'b11, 16'h9934},
    {1'b1, 20'h00011, 16'h5555, 2'b00, 16'h0000},
    {1'b0, 20'h00011, 16'h0000, 2'b11, 16'h9934},
    {1'b1, 20'hFFFFF, 16'hBEEF, 2'b11, 16'h0000},
    {1'b0, 20'hFFFFF, 16'h0000, 2'b11, 16'hBEEF},
    {1'b0, 20'h00000, 16'h0000, 2'b11, 16'h0000}
  };

  initial begin
    logic [15:0] rd;
    int lat, wait_cyc, burst_bad, t0, t9;
    repeat (2) @(negedge clk);
    chk("R1 reset pins", {24'd0, mem_cs_n, mem_cs2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n,
        req_ready, rsp_valid}, 32'b1011_1100);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00010;
    @(negedge clk);
    chk("R1 after reset", {29'd0, mem_cs_n, req_ready, rsp_valid}, 32'b100);
    wait_cyc = 1;
    while (!req_ready) begin
      @(negedge clk);
      wait_cyc++;
    end
    req_valid = 1'b0;
    chk("R2 ready wait", 32'(wait_cyc >= 2500), 32'd1);
    chk("R2 still deselected", {31'd0, mem_cs_n}, 32'd1);

    for (int i = 0; i < 12; i++) begin
      do_access(VECS[i][54], VECS[i][53:34], VECS[i][33:18], VECS[i][17:16], rd, lat);
      if (!VECS[i][54]) begin
        chk((i == 8) ? "R6 be00 ignored" : ((i == 4 || i == 6) ? "R5 lane mask" : "R3 read data"),
            32'(rd), 32'(VECS[i][15:0]));
        chk("R3 read latency", 32'(lat), 32'd3);
      end
    end

    burst_bad = 0; t0 = 0; t9 = 0;
    for (int k = 0; k < 200; k++) begin
      do_access(1'b0, 20'hFFFFF, 16'h0000, 2'b11, rd, lat);
      if (rd !== 16'hBEEF) burst_bad++;
      if (k == 0) t0 = cyc;
      if (k == 9) t9 = cyc;
    end
    chk("R7 burst data", 32'(burst_bad), 32'd0);
    chk("R9 back-to-back span", 32'(t9 - t0), 32'd36);
    repeat (10) @(negedge clk);

    chk("R2 first select", 32'(first_sel >= 2500), 32'd1);
    chk("R7 run ceiling", 32'(max_sel_run <= 750), 32'd1);
    chk("R7 forced cut", 32'(max_sel_run >= 700), 32'd1);
    chk("R8 gap width", 32'(min_gap >= 2), 32'd1);
    chk("R4 we pulse min", 32'(we_min), 32'd3);
    chk("R4 we pulse max", 32'(we_max), 32'd3);
    chk("R4 oe high in write", {31'd0, bad_oe}, 32'd0);
    chk("R4 addr data stable", {31'd0, bad_stable}, 32'd0);
    chk("R4 release order", {31'd0, bad_order}, 32'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule